// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home node for a set of memory blocks that several processing elements share. For every block it keeps a directory entry: a presence vector with one bit for each element and a dirty flag. It also keeps the home copy of the block's data. An element sends a read request or an ownership (write) request for a block. The controller looks up the entry. If the entry requires it, the controller either recalls the block from the element that currently owns it or invalidates the other sharers. It then returns the block data to the requester and updates the entry.

Coherence traffic is point-to-point. A recall names one element, and invalidations are raised on a per-element vector. Only elements marked in the presence vector are ever addressed. Requests are served one at a time. The request port is held off from the moment a request is accepted until its response has been issued. Memory stays write-back: the home copy changes only when a recalled owner returns its data.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset the request port is ready, no response, recall or invalidation is active, every directory entry is empty and clean, and block b holds the value b (zero-extended).
- R2: A read of a clean block returns the home copy, sends no recall or invalidation, and marks the requester present.
- R3: A read of a block owned by another element sends exactly one recall with the invalidate flag low (`rcl_inval` = 0) to the owner only. The response carries the data acknowledged by the owner. That data becomes the home copy, the dirty flag clears, and both owner and requester stay present.
- R4: An ownership request for a clean block raises an invalidation to exactly the present elements other than the requester. Each invalidation stays raised until that element acknowledges it, and the response follows only after every acknowledgement has arrived.
- R5: An ownership request for a block owned by another element sends exactly one recall with `rcl_inval` = 1 to the owner. The response carries the recalled data and the home copy is updated. Afterwards only the requester is present and the block is dirty.
- R6: A read or ownership request from the element that already owns a dirty block sends no message, returns the home copy, and leaves the entry unchanged.
- R7: Once a request is accepted, `req_ready` stays low until the cycle after the response.
- R8: A recall or invalidation never addresses an element whose presence bit is clear, and an invalidation never addresses the requester.
- R9: The response lasts exactly one cycle, names the requester in `rsp_pe`, and the port is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = ownership request, 0 = read |
| req_pe | input | PE_W | Requesting element |
| req_addr | input | AW | Block index |
| rsp_valid | output | 1 | Response pulse |
| rsp_pe | output | PE_W | Element the response is for |
| rsp_data | output | DATA_W | Block data returned |
| rcl_valid | output | 1 | Recall outstanding |
| rcl_pe | output | PE_W | Element being recalled |
| rcl_addr | output | AW | Block being recalled |
| rcl_inval | output | 1 | 1 = owner must also drop its copy |
| rcl_ack_valid | input | 1 | Owner returns the recalled block |
| rcl_ack_data | input | DATA_W | Recalled block data |
| inv_valid | output | N_PE | Per-element invalidation request |
| inv_addr | output | AW | Block being invalidated |
| inv_ack | input | N_PE | Per-element invalidation acknowledgement |

## Verification
A corrupted presence vector or dirty flag stays hidden until the same block is requested again. It then shows up as a recall or invalidation sent to the wrong element, as a missing message, or as stale data in the response of that next request. The bench therefore concentrates random traffic on four blocks, so that almost every request revisits an entry left by a recent one. A wrong home copy appears as a mismatched `rsp_data` on the next read of that block. A sequencing fault shows up within one transaction as a response issued before all acknowledgements or while the port is ready.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;
  typedef enum logic [2:0] {
    HS_IDLE,
    HS_LOOKUP,
    HS_RECALL,
    HS_INVWAIT,
    HS_RESPOND
  } home_state_t;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int N_PE  = 4,
  parameter int N_BLK = 16,
  localparam int AW   = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr,
  output logic [N_PE-1:0] rd_pres,
  output logic            rd_dirty,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [N_PE-1:0] wr_pres,
  input  logic            wr_dirty
);
  logic [N_PE-1:0] pres_q  [N_BLK];
  logic            dirty_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (sel) begin
        pres_q[b]  <= wr_pres;
        dirty_q[b] <= wr_dirty;
      end
    end
  end

  assign rd_pres  = pres_q[rd_addr];
  assign rd_dirty = dirty_q[rd_addr];
endmodule

// File: rtl/dir_data_store.sv
module dir_data_store #(
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] line_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_line
    logic sel;
    assign sel = we && (addr == AW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[b] <= DATA_W'(b);
      else if (sel) line_q[b] <= wdata;
    end
  end

  assign rdata = line_q[addr];
endmodule

// File: rtl/dir_home_fsm.sv
module dir_home_fsm
  import dir_home_pkg::*;
#(
  parameter int N_PE   = 4,
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = (N_BLK > 1) ? $clog2(N_BLK) : 1,
  localparam int PE_W  = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PE_W-1:0]   req_pe,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic [PE_W-1:0]   rsp_pe,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rcl_valid,
  output logic [PE_W-1:0]   rcl_pe,
  output logic [AW-1:0]     rcl_addr,
  output logic              rcl_inval,
  input  logic              rcl_ack_valid,
  input  logic [DATA_W-1:0] rcl_ack_data,
  output logic [N_PE-1:0]   inv_valid,
  output logic [AW-1:0]     inv_addr,
  input  logic [N_PE-1:0]   inv_ack,
  output logic [AW-1:0]     blk_addr,
  input  logic [N_PE-1:0]   ent_pres,
  input  logic              ent_dirty,
  output logic              ent_we,
  output logic [N_PE-1:0]   ent_wpres,
  output logic              ent_wdirty,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata
);
  home_state_t state_q, state_d;

  logic [PE_W-1:0]   pe_q;
  logic [AW-1:0]     addr_q;
  logic              wr_q;
  logic [N_PE-1:0]   pres_q;
  logic              dirty_q;
  logic [PE_W-1:0]   owner_q;
  logic [DATA_W-1:0] line_q, line_d;
  logic [N_PE-1:0]   pend_q, pend_d;
  logic              inval_q, inval_d;

  logic [N_PE-1:0]   req_bit;
  logic [PE_W-1:0]   owner_c;
  logic              other_owner;
  logic              self_owner_q;
  logic              accept, lookup_en, pend_en, line_en;

  assign accept    = req_valid && req_ready;
  assign lookup_en = (state_q == HS_LOOKUP);
  assign blk_addr  = addr_q;

  always_comb begin
    req_bit = '0;
    req_bit[pe_q] = 1'b1;
  end

  always_comb begin
    owner_c = '0;
    for (int k = 0; k < N_PE; k++) begin
      if (ent_pres[k]) owner_c = PE_W'(k);
    end
  end

  assign other_owner  = ent_dirty && (owner_c != pe_q);
  assign self_owner_q = dirty_q && (owner_q == pe_q);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    inval_d = inval_q;
    line_d  = line_q;
    pend_en = 1'b0;
    line_en = 1'b0;
    mem_we  = 1'b0;
    ent_we  = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (accept) state_d = HS_LOOKUP;
      end
      HS_LOOKUP: begin
        line_d  = mem_rdata;
        line_en = 1'b1;
        inval_d = wr_q;
        if (other_owner) begin
          state_d = HS_RECALL;
        end else if (wr_q && !ent_dirty && ((ent_pres & ~req_bit) != '0)) begin
          pend_d  = ent_pres & ~req_bit;
          pend_en = 1'b1;
          state_d = HS_INVWAIT;
        end else begin
          state_d = HS_RESPOND;
        end
      end
      HS_RECALL: begin
        if (rcl_ack_valid) begin
          mem_we  = 1'b1;
          line_d  = rcl_ack_data;
          line_en = 1'b1;
          state_d = HS_RESPOND;
        end
      end
      HS_INVWAIT: begin
        pend_d  = pend_q & ~inv_ack;
        pend_en = 1'b1;
        if (pend_d == '0) state_d = HS_RESPOND;
      end
      HS_RESPOND: begin
        ent_we  = 1'b1;
        state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  assign mem_wdata  = rcl_ack_data;
  assign ent_wpres  = wr_q ? req_bit : (pres_q | req_bit);
  assign ent_wdirty = wr_q ? 1'b1 : self_owner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q   <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      pe_q   <= req_pe;
      addr_q <= req_addr;
      wr_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= '0;
      dirty_q <= 1'b0;
      owner_q <= '0;
      inval_q <= 1'b0;
    end else if (lookup_en) begin
      pres_q  <= ent_pres;
      dirty_q <= ent_dirty;
      owner_q <= owner_c;
      inval_q <= inval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign req_ready = (state_q == HS_IDLE);
  assign rsp_valid = (state_q == HS_RESPOND);
  assign rsp_pe    = pe_q;
  assign rsp_data  = line_q;
  assign rcl_valid = (state_q == HS_RECALL);
  assign rcl_pe    = owner_q;
  assign rcl_addr  = addr_q;
  assign rcl_inval = inval_q;
  assign inv_valid = (state_q == HS_INVWAIT) ? pend_q : '0;
  assign inv_addr  = addr_q;
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int N_PE   = 4,
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = (N_BLK > 1) ? $clog2(N_BLK) : 1,
  localparam int PE_W  = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PE_W-1:0]   req_pe,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic [PE_W-1:0]   rsp_pe,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rcl_valid,
  output logic [PE_W-1:0]   rcl_pe,
  output logic [AW-1:0]     rcl_addr,
  output logic              rcl_inval,
  input  logic              rcl_ack_valid,
  input  logic [DATA_W-1:0] rcl_ack_data,
  output logic [N_PE-1:0]   inv_valid,
  output logic [AW-1:0]     inv_addr,
  input  logic [N_PE-1:0]   inv_ack
);
  logic [AW-1:0]     blk_addr;
  logic [N_PE-1:0]   ent_pres;
  logic              ent_dirty;
  logic              ent_we;
  logic [N_PE-1:0]   ent_wpres;
  logic              ent_wdirty;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;

  dir_entry_store #(.N_PE(N_PE), .N_BLK(N_BLK)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(blk_addr), .rd_pres(ent_pres), .rd_dirty(ent_dirty),
    .wr_en(ent_we), .wr_addr(blk_addr), .wr_pres(ent_wpres), .wr_dirty(ent_wdirty)
  );

  dir_data_store #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(blk_addr), .rdata(mem_rdata),
    .we(mem_we), .wdata(mem_wdata)
  );

  dir_home_fsm #(.N_PE(N_PE), .N_BLK(N_BLK), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_pe(req_pe), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_pe(rsp_pe), .rsp_data(rsp_data),
    .rcl_valid(rcl_valid), .rcl_pe(rcl_pe), .rcl_addr(rcl_addr), .rcl_inval(rcl_inval),
    .rcl_ack_valid(rcl_ack_valid), .rcl_ack_data(rcl_ack_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .blk_addr(blk_addr), .ent_pres(ent_pres), .ent_dirty(ent_dirty),
    .ent_we(ent_we), .ent_wpres(ent_wpres), .ent_wdirty(ent_wdirty),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int N_PE  = 4,
  parameter int PE_W  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [PE_W-1:0] rsp_pe,
  input logic            rcl_valid,
  input logic [PE_W-1:0] rcl_pe,
  input logic            rcl_ack_valid,
  input logic [N_PE-1:0] inv_valid,
  input logic [N_PE-1:0] inv_ack,
  input logic [N_PE-1:0] ent_pres
);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R8
  inv_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid & ~ent_pres) == '0);

  // R8
  inv_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |-> !inv_valid[rsp_pe]);

  // R8
  rcl_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_valid |-> ent_pres[rcl_pe]);

  // R3
  rcl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_valid && !rcl_ack_valid) |=> (rcl_valid && $stable(rcl_pe)));

  // R4
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(inv_valid & ~inv_ack)) |=> ((($past(inv_valid) & ~$past(inv_ack)) & ~inv_valid) == '0));

  // R4
  rsp_after_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(inv_valid & ~inv_ack)) |=> !rsp_valid);
endmodule

bind dir_home_ctrl dir_home_chk #(.N_PE(N_PE), .PE_W(PE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_pe(rsp_pe), .rcl_valid(rcl_valid), .rcl_pe(rcl_pe),
  .rcl_ack_valid(rcl_ack_valid), .inv_valid(inv_valid), .inv_ack(inv_ack),
  .ent_pres(ent_pres)
);

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
  localparam int N_PE = 4, N_BLK = 16, DATA_W = 32, AW = 4, PE_W = 2;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [PE_W-1:0] req_pe;
  logic [AW-1:0] req_addr;
  logic rsp_valid;
  logic [PE_W-1:0] rsp_pe;
  logic [DATA_W-1:0] rsp_data;
  logic rcl_valid, rcl_inval, rcl_ack_valid;
  logic [PE_W-1:0] rcl_pe;
  logic [AW-1:0] rcl_addr, inv_addr;
  logic [DATA_W-1:0] rcl_ack_data;
  logic [N_PE-1:0] inv_valid, inv_ack;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DATA_W-1:0] mem_m [N_BLK];
  logic [N_PE-1:0]   pres_m [N_BLK];
  logic              dirty_m [N_BLK];
  logic [DATA_W-1:0] cdata [N_PE][N_BLK];

  dir_home_ctrl u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input int pe, input int blk, input bit wr);
    logic [N_PE-1:0] bitv, inv_exp, inv_seen;
    logic [DATA_W-1:0] exp_data;
    int owner, rcl_cnt, cyc;
    bit exp_rcl, self_own, prev_rcl, busy_bad, tgt_bad;
    string tag;
    bitv = '0; bitv[pe] = 1'b1;
    owner = -1;
    for (int k = 0; k < N_PE; k++) if (pres_m[blk][k]) owner = k;
    self_own = dirty_m[blk] && (owner == pe);
    exp_rcl  = dirty_m[blk] && (owner != pe);
    inv_exp  = (wr && !dirty_m[blk]) ? (pres_m[blk] & ~bitv) : '0;
    exp_data = exp_rcl ? cdata[owner][blk] : mem_m[blk];
    if (self_own) tag = "R6";
    else if (exp_rcl) tag = wr ? "R5" : "R3";
    else tag = wr ? "R4" : "R2";

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_pe = PE_W'(pe); req_addr = AW'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    rcl_cnt = 0; inv_seen = '0; cyc = 0; prev_rcl = 0; busy_bad = 0; tgt_bad = 0;
    while (!rsp_valid && cyc < 1000) begin
      if (req_ready) busy_bad = 1;
      if (rcl_valid) begin
        if (!prev_rcl) begin
          rcl_cnt++;
          if (rcl_pe != PE_W'(owner) || rcl_addr != AW'(blk) || rcl_inval != wr) tgt_bad = 1;
        end
        rcl_ack_valid = ($urandom % 2) == 0;
        rcl_ack_data  = (owner >= 0) ? cdata[owner][blk] : '0;
      end else begin
        rcl_ack_valid = 1'b0;
      end
      prev_rcl = rcl_valid && !rcl_ack_valid;
      if (|inv_valid && inv_addr != AW'(blk)) tgt_bad = 1;
      inv_seen |= inv_valid;
      inv_ack = inv_valid & N_PE'($urandom);
      @(negedge clk);
      cyc++;
    end
    rcl_ack_valid = 1'b0;
    inv_ack = '0;
    chk(cyc < 1000, tag, "response arrived", 64'(cyc), 64'd1000);
    chk(!busy_bad, "R7", "ready low while busy", 64'(busy_bad), 64'd0);
    chk(!tgt_bad, "R8", "recall/inval target", 64'(tgt_bad), 64'd0);
    chk(rcl_cnt == int'(exp_rcl), tag, "recall count", 64'(rcl_cnt), 64'(exp_rcl));
    chk(inv_seen == inv_exp, tag, "invalidation set", 64'(inv_seen), 64'(inv_exp));
    chk(rsp_pe == PE_W'(pe), "R9", "rsp_pe", 64'(rsp_pe), 64'(pe));
    chk(rsp_data == exp_data, tag, "rsp_data", 64'(rsp_data), 64'(exp_data));

    if (exp_rcl) mem_m[blk] = cdata[owner][blk];
    if (wr) begin
      pres_m[blk] = bitv; dirty_m[blk] = 1'b1;
      cdata[pe][blk] = $urandom;
    end else begin
      if (!self_own) cdata[pe][blk] = exp_data;
      pres_m[blk] = pres_m[blk] | bitv;
      dirty_m[blk] = self_own;
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", "single-cycle response",
        {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    req_valid = 0; req_write = 0; req_pe = '0; req_addr = '0;
    rcl_ack_valid = 0; rcl_ack_data = '0; inv_ack = '0;
    for (int b = 0; b < N_BLK; b++) begin
      mem_m[b] = DATA_W'(b); pres_m[b] = '0; dirty_m[b] = 0;
      for (int p = 0; p < N_PE; p++) cdata[p][b] = '0;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: idle outputs during and after reset
    chk(req_ready && !rsp_valid && !rcl_valid && inv_valid == '0, "R1", "reset outputs",
        {60'd0, req_ready, rsp_valid, rcl_valid, |inv_valid}, 64'h8);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
    // R1: reset contents of blocks
    do_req(0, 5, 0);
    do_req(3, 15, 0);
    // directed sequence on block 2
    do_req(1, 2, 0);   // R2
    do_req(2, 2, 0);   // R2
    do_req(3, 2, 1);   // R4 invalidates 1 and 2
    do_req(0, 2, 0);   // R3 recall from 3
    do_req(3, 2, 1);   // R4 invalidates 0 only
    do_req(3, 2, 1);   // R6 owner writes again
    do_req(3, 2, 0);   // R6 owner reads
    do_req(1, 2, 1);   // R5 recall-invalidate from 3
    do_req(2, 2, 0);   // R3 recall from 1
    do_req(0, 2, 0);   // R2 after downgrade
    do_req(3, 2, 1);   // R4 invalidates 0,1,2
    for (int n = 0; n < 400; n++)
      do_req(int'($urandom % N_PE), int'($urandom % 4), ($urandom % 5) < 2);
    done = 1;
    summary();
    $finish;
  end
endmodule